// File: doc/BRIEF.md
# Allocation Conflict Checker

This block watches the two allocation stages of one input-queued, virtual-channel router and reports grants that would mix packets or lose flits. In every cycle it compares the output-VC grants against each other and against a per-output-VC reservation record that it keeps itself. It also compares the switch grants row by row and column by column. All of these comparisons are combinational and finish within the cycle in which the grants are presented.

When any comparison fails, the block registers a one-cycle invalidate pulse. The allocators use this pulse to cancel the allocations they made in the cycle that was checked, and the crossbar outputs use it to drop the flits that cross in that cycle. The pulse carries a cause vector, and a sticky error flag holds the event until the recovery logic clears it. A grant that is merely unwise is not a fault here: a free but wrong output VC, or an input VC that never wins, is passed through silently and left to network-level detection.

Top module: `alloc_conflict_checker`

## Requirements
- R1: While reset is held and in the cycle after it is released, `invalidate`, `err_flag` and `fault_kind` are all zero, and every output VC is unreserved.
- R2: When two or more input VCs are granted the same output VC in one cycle, `invalidate` is 1 in the next cycle and `fault_kind` bit 0 is set. A VA grant bit sits at index `ovc*NVC + ivc`, with `NVC = PORTS*VCS` and `ovc = port*VCS + vc`.
- R3: A lone grant to a free output VC in a cycle with no fault of any kind reserves that output VC. Any later grant to a reserved output VC raises `invalidate` in the next cycle with `fault_kind` bit 1 set.
- R4: When one input port is granted two or more output ports in one cycle, `invalidate` follows in the next cycle with `fault_kind` bit 2 set. An SA grant bit sits at index `in_port*PORTS + out_port`.
- R5: When two or more input ports are granted the same output port in one cycle, `invalidate` follows in the next cycle with `fault_kind` bit 3 set.
- R6: `invalidate` is 1 only in a cycle that directly follows a faulty cycle. After a clean cycle it is 0 and `fault_kind` is 0.
- R7: `err_flag` rises together with `invalidate` and stays at 1 until `err_clear` is sampled. If a fault occurs in the same cycle as the clear, the flag stays 1.
- R8: Lone grants to free output VCs, one-to-one switch grants, and long stretches with no grants at all never raise `invalidate` or `err_flag`.
- R9: Pulsing `ovc_release` for an output VC makes it free again, so a following lone grant to it raises no fault.
- R10: Grants made in a faulty cycle reserve nothing. After a duplicate grant on an output VC, a later lone grant to that output VC raises no fault.
- R11: A grant to a reserved output VC is a fault even when `ovc_release` for that same output VC arrives in the same cycle.
- R12: When several kinds of fault occur in one cycle, `fault_kind` sets the bit for every one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Synchronous reset, active low |
| va_gnt | input | NVC*NVC | VC allocator grants, bit `ovc*NVC + ivc` |
| sa_gnt | input | PORTS*PORTS | Switch allocator grants, bit `in_port*PORTS + out_port` |
| ovc_release | input | NVC | Tail flit left through this output VC; frees the reservation |
| err_clear | input | 1 | Clears the sticky error flag |
| invalidate | output | 1 | One-cycle pulse: cancel the previous cycle's allocations and drop crossing flits |
| err_flag | output | 1 | Sticky error indication |
| fault_kind | output | 4 | Cause of the pulse: bit0 VA duplicate, bit1 VA to reserved, bit2 SA fan-out, bit3 SA fan-in |

## Verification
The stimulus table sets up each fault in isolation: two requesters for one free output VC, a second grant to a reserved output VC, one input fanned out to two switch outputs, and two inputs merged onto one. Each fault type is checked only by its own cause bit, so a comparison wired to the wrong cause is caught. Clean rows with several disjoint grants separate a correct multi-hot test from one that flags any grant at all. A row that combines faults shows that causes are merged rather than prioritised. Directed sequences cover how the reservation record evolves: freeing by release, the same-cycle race between release and grant, and the rule that a cancelled cycle leaves no reservation behind.

// File: rtl/acc_pkg.sv
// Package acc_pkg
// Shared cause-vector layout for the allocation conflict checker.
// Assumes nothing beyond the four fault classes listed here.
package acc_pkg;
    localparam int KIND_W         = 4;
    localparam int KIND_VA_DUP    = 0;  // output VC granted to several input VCs
    localparam int KIND_VA_RESV   = 1;  // output VC granted while reserved
    localparam int KIND_SA_FANOUT = 2;  // one input sent to several outputs
    localparam int KIND_SA_FANIN  = 3;  // several inputs sent to one output

    typedef logic [KIND_W-1:0] fault_kind_t;
endpackage

// File: rtl/acc_va_check.sv
// Module acc_va_check
// Compares VC allocator grants against each other and against the reservation
// record, and owns that record. Grant layout: bit ovc*NIVC + ivc.
// Assumes the top reports whether the whole cycle was clean (cycle_ok), since
// grants of a cancelled cycle must not reserve anything.
module acc_va_check #(
    parameter int NOVC = 10,
    parameter int NIVC = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NOVC*NIVC-1:0] va_gnt,
    input  logic [NOVC-1:0]      ovc_release,
    input  logic                 cycle_ok,
    output logic                 dup_hit,
    output logic                 resv_hit,
    output logic [NOVC-1:0]      resv_state
);
    localparam logic [NIVC-1:0] ONE = NIVC'(1);

    logic [NOVC-1:0] ovc_any;    // output VC received at least one grant
    logic [NOVC-1:0] ovc_multi;  // output VC received two or more grants
    logic [NOVC-1:0] ovc_clash;  // output VC granted while reserved
    logic [NOVC-1:0] resv_q;

    for (genvar o = 0; o < NOVC; o++) begin : g_ovc
        logic [NIVC-1:0] row;
        assign row          = va_gnt[o*NIVC +: NIVC];
        assign ovc_any[o]   = |row;
        assign ovc_multi[o] = |(row & (row - ONE));
        assign ovc_clash[o] = ovc_any[o] & resv_q[o];
    end

    // Reduce per-output-VC results to the two fault classes.
    always_comb begin
        dup_hit  = |ovc_multi;
        resv_hit = |ovc_clash;
    end

    // Reservation record: release frees, a grant in a clean cycle reserves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= (resv_q & ~ovc_release) | (cycle_ok ? ovc_any : '0);
        end
    end

    assign resv_state = resv_q;
endmodule

// File: rtl/acc_sa_check.sv
// Module acc_sa_check
// Compares switch allocator grants row by row (fan-out of one input) and
// column by column (fan-in on one output). Layout: bit in*PORTS + out.
// Purely combinational; assumes the grant matrix is stable within the cycle.
module acc_sa_check #(
    parameter int PORTS = 5
) (
    input  logic [PORTS*PORTS-1:0] sa_gnt,
    output logic                   fanout_hit,
    output logic                   fanin_hit
);
    localparam logic [PORTS-1:0] ONE = PORTS'(1);

    logic [PORTS-1:0] row_multi;
    logic [PORTS-1:0] col_multi;

    for (genvar i = 0; i < PORTS; i++) begin : g_row
        logic [PORTS-1:0] row;
        assign row          = sa_gnt[i*PORTS +: PORTS];
        assign row_multi[i] = |(row & (row - ONE));
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_col
        logic [PORTS-1:0] col;
        for (genvar i = 0; i < PORTS; i++) begin : g_bit
            assign col[i] = sa_gnt[i*PORTS + o];
        end
        assign col_multi[o] = |(col & (col - ONE));
    end

    // Reduce row and column results to the two switch fault classes.
    always_comb begin
        fanout_hit = |row_multi;
        fanin_hit  = |col_multi;
    end
endmodule

// File: rtl/acc_err_reg.sv
// Module acc_err_reg
// Registers the cause vector into a one-cycle invalidate pulse and a sticky
// flag. Assumes kind_now is valid for the cycle being checked.
module acc_err_reg (
    input  logic                clk,
    input  logic                rst_n,
    input  acc_pkg::fault_kind_t kind_now,
    input  logic                err_clear,
    output logic                invalidate,
    output logic                err_flag,
    output acc_pkg::fault_kind_t fault_kind
);
    logic viol;
    assign viol = |kind_now;

    // Pulse and cause: hold exactly the verdict of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            invalidate <= 1'b0;
            fault_kind <= '0;
        end else begin
            invalidate <= viol;
            fault_kind <= kind_now;
        end
    end

    // Sticky flag: a new fault wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else begin
            err_flag <= (err_flag & ~err_clear) | viol;
        end
    end
endmodule

// File: rtl/alloc_conflict_checker.sv
// Module alloc_conflict_checker
// Runtime monitor for one router's VC and switch allocators. All comparisons
// run in the cycle the grants are presented; the verdict is registered into
// a one-cycle invalidate pulse plus cause, and a sticky flag.
// Assumes ovc_release is pulsed when a tail flit leaves via that output VC.
module alloc_conflict_checker #(
    parameter int PORTS = 5,
    parameter int VCS   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [(PORTS*VCS)**2-1:0]  va_gnt,
    input  logic [PORTS*PORTS-1:0]     sa_gnt,
    input  logic [PORTS*VCS-1:0]       ovc_release,
    input  logic                       err_clear,
    output logic                       invalidate,
    output logic                       err_flag,
    output logic [acc_pkg::KIND_W-1:0] fault_kind
);
    import acc_pkg::*;

    localparam int NVC = PORTS * VCS;

    logic            dup_hit, resv_hit, fanout_hit, fanin_hit;
    logic            viol_now;
    logic [NVC-1:0]  resv_state;
    fault_kind_t     kind_now;

    acc_va_check #(.NOVC(NVC), .NIVC(NVC)) i_va (
        .clk        (clk),
        .rst_n      (rst_n),
        .va_gnt     (va_gnt),
        .ovc_release(ovc_release),
        .cycle_ok   (~viol_now),
        .dup_hit    (dup_hit),
        .resv_hit   (resv_hit),
        .resv_state (resv_state)
    );

    acc_sa_check #(.PORTS(PORTS)) i_sa (
        .sa_gnt    (sa_gnt),
        .fanout_hit(fanout_hit),
        .fanin_hit (fanin_hit)
    );

    // Assemble the cause vector of the current cycle.
    always_comb begin
        kind_now                 = '0;
        kind_now[KIND_VA_DUP]    = dup_hit;
        kind_now[KIND_VA_RESV]   = resv_hit;
        kind_now[KIND_SA_FANOUT] = fanout_hit;
        kind_now[KIND_SA_FANIN]  = fanin_hit;
        viol_now                 = |kind_now;
    end

    acc_err_reg i_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind_now  (kind_now),
        .err_clear (err_clear),
        .invalidate(invalidate),
        .err_flag  (err_flag),
        .fault_kind(fault_kind)
    );
endmodule

// File: rtl/acc_checker.sv
// Module acc_checker
// Temporal properties of alloc_conflict_checker, attached by bind.
// Sees the ports plus the reservation record and the current-cycle verdict.
module acc_checker #(
    parameter int PORTS = 5,
    parameter int VCS   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [(PORTS*VCS)**2-1:0] va_gnt,
    input logic [PORTS*PORTS-1:0]    sa_gnt,
    input logic [PORTS*VCS-1:0]      ovc_release,
    input logic                      err_clear,
    input logic                      invalidate,
    input logic                      err_flag,
    input logic [3:0]                fault_kind,
    input logic [PORTS*VCS-1:0]      resv_state,
    input logic                      viol_now
);
    localparam int NVC = PORTS * VCS;

    for (genvar o = 0; o < NVC; o++) begin : g_ovc
        // R2: several requesters on one output VC
        assert_va_dup_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(va_gnt[o*NVC +: NVC]) > 1) |=> (invalidate && fault_kind[0]));
        // R3 / R11: grant to a reserved output VC, release or not
        assert_va_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (resv_state[o] && (|va_gnt[o*NVC +: NVC])) |=> (invalidate && fault_kind[1]));
        // R9: release without a new grant frees the output VC
        assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ovc_release[o] && !(|va_gnt[o*NVC +: NVC])) |=> !resv_state[o]);
    end

    for (genvar i = 0; i < PORTS; i++) begin : g_row
        // R4: one input fanned out to several outputs
        assert_sa_fanout_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(sa_gnt[i*PORTS +: PORTS]) > 1) |=> (invalidate && fault_kind[2]));
    end

    // R6: a clean cycle is followed by no pulse and no cause
    assert_clean_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_now |=> (!invalidate && fault_kind == 4'd0));
    // R7: flag holds until cleared
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> err_flag);
    // R7: pulse never appears without the flag
    assert_flag_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> err_flag);
    // R6: the pulse always carries a cause
    assert_pulse_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> (fault_kind != 4'd0));
endmodule

bind alloc_conflict_checker acc_checker #(.PORTS(PORTS), .VCS(VCS)) i_acc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .va_gnt     (va_gnt),
    .sa_gnt     (sa_gnt),
    .ovc_release(ovc_release),
    .err_clear  (err_clear),
    .invalidate (invalidate),
    .err_flag   (err_flag),
    .fault_kind (fault_kind),
    .resv_state (resv_state),
    .viol_now   (viol_now)
);

// File: tb/test_alloc_conflict_checker.sv
module test_alloc_conflict_checker;
    localparam int PORTS = 3;
    localparam int VCS   = 2;
    localparam int NVC   = PORTS * VCS;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NVC*NVC-1:0]    va_gnt = '0;
    logic [PORTS*PORTS-1:0] sa_gnt = '0;
    logic [NVC-1:0]        ovc_release = '0;
    logic                  err_clear = 1'b0;
    logic                  invalidate, err_flag;
    logic [3:0]            fault_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    alloc_conflict_checker #(.PORTS(PORTS), .VCS(VCS)) i_alloc_conflict_checker (
        .clk(clk), .rst_n(rst_n), .va_gnt(va_gnt), .sa_gnt(sa_gnt),
        .ovc_release(ovc_release), .err_clear(err_clear),
        .invalidate(invalidate), .err_flag(err_flag), .fault_kind(fault_kind)
    );

    // Row: optional pre-grant, up to two VA grants, optional release,
    // up to two SA grants, expected cause of the test cycle.
    typedef struct packed {
        logic pv; logic [2:0] po; logic [2:0] pi;
        logic av; logic [2:0] ao; logic [2:0] ai;
        logic bv; logic [2:0] bo; logic [2:0] bi;
        logic rv; logic [2:0] ro;
        logic sav; logic [1:0] sai; logic [1:0] sao;
        logic sbv; logic [1:0] sbi; logic [1:0] sbo;
        logic [3:0] kind;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t TBL [NROWS] = '{
        // R8: wrong but free output VC, one switch grant
        '{1'b0,3'd0,3'd0, 1'b1,3'd0,3'd1, 1'b0,3'd0,3'd0, 1'b0,3'd0, 1'b1,2'd0,2'd1, 1'b0,2'd0,2'd0, 4'b0000},
        // R2: duplicate on output VC 2
        '{1'b0,3'd0,3'd0, 1'b1,3'd2,3'd0, 1'b1,3'd2,3'd3, 1'b0,3'd0, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0, 4'b0001},
        // R3: grant to reserved output VC 4
        '{1'b1,3'd4,3'd2, 1'b1,3'd4,3'd5, 1'b0,3'd0,3'd0, 1'b0,3'd0, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0, 4'b0010},
        // R4: input 1 to outputs 0 and 2
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0, 1'b1,2'd1,2'd0, 1'b1,2'd1,2'd2, 4'b0100},
        // R5: inputs 0 and 2 onto output 2
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0, 1'b1,2'd0,2'd2, 1'b1,2'd2,2'd2, 4'b1000},
        // R11: release and new grant on reserved output VC 1 together
        '{1'b1,3'd1,3'd0, 1'b1,3'd1,3'd4, 1'b0,3'd0,3'd0, 1'b1,3'd1, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0, 4'b0010},
        // R3: same input VC regranted a reserved output VC
        '{1'b1,3'd3,3'd1, 1'b1,3'd3,3'd1, 1'b0,3'd0,3'd0, 1'b0,3'd0, 1'b0,2'd0,2'd0, 1'b0,2'd0,2'd0, 4'b0010},
        // R12: VA duplicate plus SA fan-in
        '{1'b0,3'd0,3'd0, 1'b1,3'd5,3'd0, 1'b1,3'd5,3'd1, 1'b0,3'd0, 1'b1,2'd0,2'd0, 1'b1,2'd1,2'd0, 4'b1001},
        // R8: disjoint grants, one output VC already held elsewhere
        '{1'b1,3'd0,3'd0, 1'b1,3'd1,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0, 1'b1,2'd0,2'd0, 1'b1,2'd1,2'd1, 4'b0000},
        // R8: two free output VCs, one switch grant
        '{1'b0,3'd0,3'd0, 1'b1,3'd0,3'd2, 1'b1,3'd5,3'd3, 1'b0,3'd0, 1'b1,2'd2,2'd1, 1'b0,2'd0,2'd0, 4'b0000}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge, then settle at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        va_gnt = '0; sa_gnt = '0; ovc_release = '0; err_clear = 1'b0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    function automatic logic [NVC*NVC-1:0] vbit(input int o, input int i);
        logic [NVC*NVC-1:0] v = '0;
        v[o*NVC + i] = 1'b1;
        return v;
    endfunction

    function automatic logic [PORTS*PORTS-1:0] sbit(input int i, input int o);
        logic [PORTS*PORTS-1:0] v = '0;
        v[i*PORTS + o] = 1'b1;
        return v;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        rst_n = 1'b0;
        step();
        // R1: outputs during reset
        check("R1 invalidate in reset", int'(invalidate), 0);
        check("R1 flag in reset", int'(err_flag), 0);
        rst_n = 1'b1;
        step();
        check("R1 kind after reset", int'(fault_kind), 0);
        check("R1 flag after reset", int'(err_flag), 0);

        for (int r = 0; r < NROWS; r++) begin
            do_reset();
            if (TBL[r].pv) begin
                va_gnt = vbit(TBL[r].po, TBL[r].pi);
                step();
                check("R3 pre-grant clean", int'(invalidate), 0);
                idle();
            end
            if (TBL[r].av) va_gnt |= vbit(TBL[r].ao, TBL[r].ai);
            if (TBL[r].bv) va_gnt |= vbit(TBL[r].bo, TBL[r].bi);
            if (TBL[r].rv) ovc_release[TBL[r].ro] = 1'b1;
            if (TBL[r].sav) sa_gnt |= sbit(TBL[r].sai, TBL[r].sao);
            if (TBL[r].sbv) sa_gnt |= sbit(TBL[r].sbi, TBL[r].sbo);
            step();
            idle();
            check($sformatf("R2-R5/R8/R12 row %0d kind", r), int'(fault_kind), int'(TBL[r].kind));
            check($sformatf("R2-R5/R8 row %0d invalidate", r), int'(invalidate), int'(TBL[r].kind != 0));
            check($sformatf("R7 row %0d flag", r), int'(err_flag), int'(TBL[r].kind != 0));
            step();
            check($sformatf("R6 row %0d pulse ends", r), int'(invalidate), 0);
            check($sformatf("R7 row %0d flag held", r), int'(err_flag), int'(TBL[r].kind != 0));
        end

        // R9: release frees a reserved output VC
        do_reset();
        va_gnt = vbit(2, 0); step(); idle();
        ovc_release[2] = 1'b1; step(); idle();
        va_gnt = vbit(2, 1); step(); idle();
        check("R9 regrant after release", int'(invalidate), 0);
        check("R9 no flag", int'(err_flag), 0);

        // R10: a cancelled cycle leaves no reservation
        do_reset();
        va_gnt = vbit(3, 0) | vbit(3, 4); step(); idle();
        check("R10 duplicate flagged", int'(fault_kind), 1);
        va_gnt = vbit(3, 0); step(); idle();
        check("R10 lone grant after cancel", int'(invalidate), 0);

        // R7: sticky until clear, fault beats clear
        do_reset();
        sa_gnt = sbit(0, 0) | sbit(0, 1); step(); idle();
        repeat (5) step();
        check("R7 flag persists", int'(err_flag), 1);
        err_clear = 1'b1; step(); idle();
        check("R7 flag cleared", int'(err_flag), 0);
        err_clear = 1'b1; sa_gnt = sbit(1, 2) | sbit(2, 2); step(); idle();
        check("R7 fault wins over clear", int'(err_flag), 1);
        check("R5 fan-in with clear", int'(fault_kind), 8);

        // R8: long starvation with no grants
        do_reset();
        repeat (50) step();
        check("R8 starvation not flagged", int'(err_flag), 0);

        // R6: back-to-back faults keep the pulse, then it drops
        do_reset();
        va_gnt = vbit(0, 0) | vbit(0, 1); step();
        check("R6 first pulse", int'(invalidate), 1);
        step(); idle();
        check("R6 second pulse", int'(invalidate), 1);
        step();
        check("R6 pulse drops", int'(invalidate), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule